// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit executes a group of custom-opcode bit-manipulation operations for a 64-bit core. Each cycle it may receive one instruction word, the value of the first source register and a strobe that marks the pair as valid. It decodes the word, computes the result from the source value, and registers the destination index, the result, a write-enable and an illegal-instruction flag. These outputs appear on the clock edge that samples the strobe.

The group contains the following operations:
- signed and unsigned bitfield extraction
- leading-zero counting of the source or of its complement
- rotation right by an immediate, on the full 64-bit value or on its low word
- byte reversal, on the full value or on its low word
- a per-byte zero test

A separate enable input gates the whole group. When the enable is low, a word carrying the custom opcode is rejected as illegal. Words with any other major opcode belong to other units, and this one ignores them.

Top module: `bitmanip_xu`

## Requirements
- R1: Only words with bits 6:0 equal to 0001011 are handled. For any other major opcode, the cycle after the strobe shows write-enable low and illegal low. For a handled word, the destination index comes from bits 11:7.
- R2: With funct3 (bits 14:12) equal to 010 (signed) or 011 (unsigned), the result is source bits hi..lo, moved down to bit 0. Here hi is bits 31:26 and lo is bits 25:20. The field is sign-extended from its top bit (signed) or zero-extended (unsigned) to 64 bits.
- R3: An extract whose lo is greater than its hi is accepted, so illegal stays low, but write-enable stays low.
- R4: Funct3 001, bits 24:20 zero and bits 31:25 equal to 1000011 give the leading-zero count of the source. Bits 31:25 equal to 1000010 give the leading-zero count of the complemented source. An all-zero operand counts 64.
- R5: Funct3 001 with bits 31:26 equal to 000100 rotates the full 64-bit source right by the amount in bits 25:20.
- R6: Funct3 001 with bits 31:25 equal to 0001010 rotates the low 32 source bits right by the amount in bits 24:20. The 32-bit result is sign-extended to 64 bits, and the upper source bits have no effect.
- R7: Funct3 001, bits 24:20 zero and bits 31:25 equal to 1000001 reverse the order of all eight source bytes.
- R8: Funct3 001, bits 24:20 zero and bits 31:25 equal to 1001000 reverse the four low source bytes and sign-extend the word to 64 bits.
- R9: Funct3 001, bits 24:20 zero and bits 31:25 equal to 1000000 set each result byte to 0xFF where the matching source byte is zero, and to 0x00 elsewhere.
- R10: When the enable input is low, any word with the custom opcode raises illegal and keeps write-enable low.
- R11: A custom-opcode word that matches no pattern above raises illegal and keeps write-enable low. This includes a unary operation with nonzero bits 24:20 and a funct3 outside 001, 010 and 011. Write-enable and illegal are never high together.
- R12: Outputs are registered one cycle after the strobe. Write-enable and illegal are low in any cycle not preceded by a strobe, and all outputs are zero after a synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operand are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | XLEN | First source register value |
| in_ext_en | input | 1 | Enable for this instruction group |
| out_rd | output | 5 | Destination register index |
| out_result | output | XLEN | Computed result |
| out_wen | output | 1 | Register write request |
| out_illegal | output | 1 | Illegal-instruction report |

## Verification
Several properties are checked on every cycle:
- write-enable and illegal are mutually exclusive
- both flags stay silent unless a strobe came the cycle before
- foreign opcodes are ignored, and a disabled unit rejects custom words
- an inverted extract field suppresses the write
- both low-word forms sign-extend their result

The actual arithmetic is shown only by the scoreboard scenarios. These cover the counts at 0 and 64, rotations by 0 and 63, field extremes of extraction, byte order, the per-byte zero pattern, and the insensitivity of the low-word forms to the upper source bits.

// File: rtl/bxu_pkg.sv
// Package: shared constants and the operation encoding used inside the
// bit-manipulation execution unit. Assumes a 32-bit instruction word.
package bxu_pkg;

    localparam logic [6:0] BX_OPCODE = 7'b0001011;

    typedef enum logic [3:0] {
        BX_NONE,
        BX_EXT_S,
        BX_EXT_U,
        BX_LZ_INV,
        BX_LZ,
        BX_ROR,
        BX_ROR_W,
        BX_REV,
        BX_REV_W,
        BX_ZTEST
    } bx_op_e;

endpackage

// File: rtl/bxu_decode.sv
// Module: bxu_decode
// Turns an instruction word into an internal operation code plus the two
// 6-bit immediate fields. Flags whether the word carries the custom opcode
// (claim), whether it is a legal member of the group with the group enabled
// (legal), and whether an extract has an inverted field (empty).
// Assumes: purely combinational; the caller qualifies outputs with a strobe.
module bxu_decode
    import bxu_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        enable,
    output bx_op_e      op,
    output logic [5:0]  fld_hi,
    output logic [5:0]  fld_lo,
    output logic [4:0]  rd,
    output logic        claim,
    output logic        legal,
    output logic        empty
);

    logic [2:0] funct3;
    logic [6:0] top7;
    logic [4:0] mid5;
    logic       unused_rs1_bits;

    assign funct3 = instr[14:12];
    assign top7   = instr[31:25];
    assign mid5   = instr[24:20];
    assign fld_hi = instr[31:26];
    assign fld_lo = instr[25:20];
    assign rd     = instr[11:7];
    assign claim  = (instr[6:0] == BX_OPCODE);
    // Source index is resolved by the register file, not here.
    assign unused_rs1_bits = ^instr[19:15];

    // Pattern match of funct3 and upper bits onto an operation.
    always_comb begin
        op = BX_NONE;
        unique case (funct3)
            3'b010: op = BX_EXT_S;
            3'b011: op = BX_EXT_U;
            3'b001: begin
                if (top7[6:1] == 6'b000100) begin
                    op = BX_ROR;
                end else if (top7 == 7'b0001010) begin
                    op = BX_ROR_W;
                end else if (mid5 == 5'd0) begin
                    case (top7)
                        7'b1000010: op = BX_LZ_INV;
                        7'b1000011: op = BX_LZ;
                        7'b1000001: op = BX_REV;
                        7'b1001000: op = BX_REV_W;
                        7'b1000000: op = BX_ZTEST;
                        default:    op = BX_NONE;
                    endcase
                end
            end
            default: op = BX_NONE;
        endcase
    end

    // Legality needs the opcode, the group enable and a matched pattern.
    assign legal = claim && enable && (op != BX_NONE);

    // An extract with lo above hi writes nothing.
    assign empty = ((op == BX_EXT_S) || (op == BX_EXT_U)) && (fld_lo > fld_hi);

endmodule

// File: rtl/bxu_lzc.sv
// Module: bxu_lzc
// Counts leading zeros of a W-bit operand; an all-zero operand gives W.
// Assumes: W is a power of two; combinational.
module bxu_lzc #(
    parameter int W  = 64,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  operand,
    output logic [CW-1:0] count
);

    // Scan upward so the highest set bit decides the count.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (operand[i]) count = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/bxu_alu.sv
// Module: bxu_alu
// Computes every operation of the group in parallel and selects one.
// Assumes: XLEN is 64, so the 6-bit immediates span the full register;
// the low-word forms act on bits 31:0. Combinational.
module bxu_alu
    import bxu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int NB   = XLEN / 8,
    localparam int SHW  = $clog2(XLEN),
    localparam int CW   = SHW + 1
) (
    input  bx_op_e            op,
    input  logic [XLEN-1:0]   src,
    input  logic [5:0]        fld_hi,
    input  logic [5:0]        fld_lo,
    output logic [XLEN-1:0]   result
);

    logic [SHW:0]      left_amt;
    logic [SHW:0]      right_amt;
    logic [XLEN-1:0]   up;
    logic [XLEN-1:0]   ext_u;
    logic [XLEN-1:0]   ext_s;
    logic [CW-1:0]     lz_plain;
    logic [CW-1:0]     lz_inv;
    logic [2*XLEN-1:0] ror_dbl;
    logic [63:0]       rorw_dbl;
    logic [XLEN-1:0]   ror_full;
    logic [XLEN-1:0]   ror_word;
    logic [XLEN-1:0]   rev_full;
    logic [31:0]       rev_lo;
    logic [XLEN-1:0]   rev_word;
    logic [XLEN-1:0]   zmask;

    // Bitfield extract: push the field to the top, then shift it down.
    always_comb begin
        left_amt  = (SHW+1)'(XLEN - 1) - (SHW+1)'(fld_hi);
        right_amt = left_amt + (SHW+1)'(fld_lo);
        up        = src << left_amt;
        ext_u     = up >> right_amt;
        ext_s     = XLEN'($signed(up) >>> right_amt);
    end

    // Leading-zero counters on the source and its complement.
    bxu_lzc #(.W(XLEN)) u_lz_plain (.operand(src),  .count(lz_plain));
    bxu_lzc #(.W(XLEN)) u_lz_inv   (.operand(~src), .count(lz_inv));

    // Rotations: double the operand and shift right.
    always_comb begin
        ror_dbl  = {src, src} >> fld_lo;
        ror_full = ror_dbl[XLEN-1:0];
        rorw_dbl = {src[31:0], src[31:0]} >> fld_lo[4:0];
        ror_word = {{(XLEN-32){rorw_dbl[31]}}, rorw_dbl[31:0]};
    end

    // Byte reversal and per-byte zero test, one slice per byte.
    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign rev_full[8*g +: 8] = src[XLEN-8-8*g +: 8];
        assign zmask[8*g +: 8]    = {8{~|src[8*g +: 8]}};
    end
    for (genvar g = 0; g < 4; g++) begin : g_word_byte
        assign rev_lo[8*g +: 8] = src[24-8*g +: 8];
    end
    assign rev_word = {{(XLEN-32){rev_lo[31]}}, rev_lo};

    // Result selection by operation.
    always_comb begin
        unique case (op)
            BX_EXT_S:  result = ext_s;
            BX_EXT_U:  result = ext_u;
            BX_LZ_INV: result = XLEN'(lz_inv);
            BX_LZ:     result = XLEN'(lz_plain);
            BX_ROR:    result = ror_full;
            BX_ROR_W:  result = ror_word;
            BX_REV:    result = rev_full;
            BX_REV_W:  result = rev_word;
            BX_ZTEST:  result = zmask;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/bitmanip_xu.sv
// Module: bitmanip_xu
// Top of the bit-manipulation execution unit. Decodes one instruction per
// strobe, computes the result and registers destination, result, write
// enable and illegal flag one cycle later.
// Assumes: a 64-bit core; the register file applies the write and the core
// turns the illegal flag into a trap.
module bitmanip_xu
    import bxu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_rs1,
    input  logic            in_ext_en,
    output logic [4:0]      out_rd,
    output logic [XLEN-1:0] out_result,
    output logic            out_wen,
    output logic            out_illegal
);

    bx_op_e          dec_op;
    logic [5:0]      dec_hi;
    logic [5:0]      dec_lo;
    logic [4:0]      dec_rd;
    logic            dec_claim;
    logic            dec_legal;
    logic            dec_empty;
    logic [XLEN-1:0] alu_result;

    bxu_decode u_decode (
        .instr  (in_instr),
        .enable (in_ext_en),
        .op     (dec_op),
        .fld_hi (dec_hi),
        .fld_lo (dec_lo),
        .rd     (dec_rd),
        .claim  (dec_claim),
        .legal  (dec_legal),
        .empty  (dec_empty)
    );

    bxu_alu #(.XLEN(XLEN)) u_alu (
        .op     (dec_op),
        .src    (in_rs1),
        .fld_hi (dec_hi),
        .fld_lo (dec_lo),
        .result (alu_result)
    );

    // Output register: flags every cycle, data only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            out_result  <= '0;
        end else begin
            out_wen     <= in_valid && dec_legal && !dec_empty;
            out_illegal <= in_valid && dec_claim && !dec_legal;
            if (in_valid) begin
                out_rd     <= dec_rd;
                out_result <= alu_result;
            end
        end
    end

    // R11
    wen_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_wen && out_illegal));

    // R12
    flag_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wen || out_illegal) |-> $past(in_valid));

    // R1
    foreign_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[6:0] != BX_OPCODE) |=> (!out_wen && !out_illegal));

    // R10
    disabled_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ext_en && in_instr[6:0] == BX_OPCODE) |=> (out_illegal && !out_wen));

    // R3
    empty_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ext_en && in_instr[6:0] == BX_OPCODE && in_instr[14:13] == 2'b01
         && in_instr[25:20] > in_instr[31:26]) |=> (!out_wen && !out_illegal));

    // R6
    ror_word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_legal && dec_op == BX_ROR_W)
        |=> (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));

    // R8
    rev_word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_legal && dec_op == BX_REV_W)
        |=> (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));

endmodule

// File: tb/bitmanip_xu_test.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares them one cycle after each strobe.
module bitmanip_xu_test;

    localparam logic [6:0] OPC = 7'b0001011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [63:0] in_rs1 = '0;
    logic        in_ext_en = 1'b0;
    logic [4:0]  out_rd;
    logic [63:0] out_result;
    logic        out_wen;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic        wen;
        logic        ill;
        logic [4:0]  rd;
        logic [63:0] res;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    bitmanip_xu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs1(in_rs1), .in_ext_en(in_ext_en), .out_rd(out_rd),
        .out_result(out_result), .out_wen(out_wen), .out_illegal(out_illegal)
    );

    function automatic logic [31:0] enc_ext(input bit sgn, input logic [5:0] hi,
                                            input logic [5:0] lo, input logic [4:0] rd);
        return {hi, lo, 5'd3, (sgn ? 3'b010 : 3'b011), rd, OPC};
    endfunction

    function automatic logic [31:0] enc_un(input logic [6:0] f7, input logic [4:0] mid,
                                           input logic [4:0] rd);
        return {f7, mid, 5'd3, 3'b001, rd, OPC};
    endfunction

    function automatic logic [31:0] enc_ror(input logic [5:0] sh, input logic [4:0] rd);
        return {6'b000100, sh, 5'd3, 3'b001, rd, OPC};
    endfunction

    function automatic logic [31:0] enc_rorw(input logic [4:0] sh, input logic [4:0] rd);
        return {7'b0001010, sh, 5'd3, 3'b001, rd, OPC};
    endfunction

    function automatic logic [63:0] ref_ror(input logic [63:0] v, input int sh);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[(i + sh) % 64];
        return r;
    endfunction

    // Driver: present one word for one cycle and queue its expectation.
    task automatic issue(input logic [31:0] ins, input logic [63:0] src, input logic en,
                         input logic ew, input logic ei, input logic [63:0] eres,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = ins;
        in_rs1    = src;
        in_ext_en = en;
        e.wen = ew; e.ill = ei; e.rd = ins[11:7]; e.res = eres;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_instr = $urandom;
        in_rs1   = {$urandom, $urandom};
    endtask

    // Monitor: sample 2 ns after each edge.
    always @(posedge clk) begin
        logic was;
        exp_t e;
        string t;
        was = in_valid && rst_n;
        #2;
        if (was) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12: output without expectation wen=%b ill=%b", out_wen, out_illegal);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_wen !== e.wen || out_illegal !== e.ill ||
                    (e.wen && (out_rd !== e.rd || out_result !== e.res))) begin
                    errors++;
                    $display("FAIL %s: got wen=%b ill=%b rd=%0d res=%h exp wen=%b ill=%b rd=%0d res=%h",
                             t, out_wen, out_illegal, out_rd, out_result, e.wen, e.ill, e.rd, e.res);
                end
            end
        end else if (rst_n) begin
            checks++;
            if (out_wen !== 1'b0 || out_illegal !== 1'b0) begin
                errors++;
                $display("FAIL R12 idle: got wen=%b ill=%b exp 0 0", out_wen, out_illegal);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        checks++;
        if (out_wen !== 0 || out_illegal !== 0 || out_rd !== 0 || out_result !== 0) begin
            errors++;
            $display("FAIL R12 reset: got wen=%b ill=%b rd=%0d res=%h exp all zero",
                     out_wen, out_illegal, out_rd, out_result);
        end
        rst_n = 1'b1;
        idle();

        // R2 extract
        issue(enc_ext(1, 15, 8, 5'd4), 64'h0000_0000_0000_8A00, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FF8A, "R2 sext");
        issue(enc_ext(0, 15, 8, 5'd5), 64'h0000_0000_0000_8A00, 1, 1, 0, 64'h0000_0000_0000_008A, "R2 zext");
        issue(enc_ext(1, 63, 0, 5'd6), 64'h8000_0000_0000_0001, 1, 1, 0, 64'h8000_0000_0000_0001, "R2 full");
        issue(enc_ext(1, 5, 5, 5'd7), 64'h0000_0000_0000_0020, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 1bit s");
        issue(enc_ext(0, 5, 5, 5'd8), 64'h0000_0000_0000_0020, 1, 1, 0, 64'h1, "R2 1bit u");
        issue(enc_ext(0, 63, 60, 5'd9), 64'hA000_0000_0000_0000, 1, 1, 0, 64'hA, "R2 top");
        // R3 inverted field
        issue(enc_ext(0, 3, 4, 5'd10), 64'hFFFF, 1, 0, 0, 64'h0, "R3 empty");
        idle();
        // R4 counts
        issue(enc_un(7'b1000011, 5'd0, 5'd11), 64'h0, 1, 1, 0, 64'd64, "R4 lz zero");
        issue(enc_un(7'b1000011, 5'd0, 5'd12), 64'h0000_0100_0000_0000, 1, 1, 0, 64'd23, "R4 lz mid");
        issue(enc_un(7'b1000011, 5'd0, 5'd13), 64'h8000_0000_0000_0000, 1, 1, 0, 64'd0, "R4 lz top");
        issue(enc_un(7'b1000010, 5'd0, 5'd14), 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 64'd64, "R4 ffz ones");
        issue(enc_un(7'b1000010, 5'd0, 5'd15), 64'hFFF0_0000_0000_0000, 1, 1, 0, 64'd12, "R4 ffz mid");
        issue(enc_un(7'b1000010, 5'd0, 5'd16), 64'h0, 1, 1, 0, 64'd0, "R4 ffz zero");
        // R5 rotate
        issue(enc_ror(6'd4, 5'd17), 64'h0123_4567_89AB_CDEF, 1, 1, 0, 64'hF012_3456_789A_BCDE, "R5 ror4");
        issue(enc_ror(6'd0, 5'd18), 64'h0123_4567_89AB_CDEF, 1, 1, 0, 64'h0123_4567_89AB_CDEF, "R5 ror0");
        issue(enc_ror(6'd63, 5'd19), 64'h0123_4567_89AB_CDEF, 1, 1, 0, 64'h0246_8ACF_1357_9BDE, "R5 ror63");
        for (int s = 1; s < 64; s += 7)
            issue(enc_ror(6'(s), 5'd20), 64'hDEAD_BEEF_0BAD_F00D, 1, 1, 0,
                  ref_ror(64'hDEAD_BEEF_0BAD_F00D, s), "R5 sweep");
        // R6 word rotate
        issue(enc_rorw(5'd1, 5'd21), 64'hABCD_EF01_0000_0001, 1, 1, 0, 64'hFFFF_FFFF_8000_0000, "R6 rorw1");
        issue(enc_rorw(5'd8, 5'd22), 64'hFFFF_FFFF_1234_5678, 1, 1, 0, 64'h0000_0000_7812_3456, "R6 rorw8");
        issue(enc_rorw(5'd0, 5'd23), 64'h5555_5555_8765_4321, 1, 1, 0, 64'hFFFF_FFFF_8765_4321, "R6 rorw0");
        // R7, R8 byte reversal
        issue(enc_un(7'b1000001, 5'd0, 5'd24), 64'h0102_0304_0506_0708, 1, 1, 0, 64'h0807_0605_0403_0201, "R7 rev");
        issue(enc_un(7'b1001000, 5'd0, 5'd25), 64'hFFFF_FFFF_1122_3384, 1, 1, 0, 64'hFFFF_FFFF_8433_2211, "R8 revw neg");
        issue(enc_un(7'b1001000, 5'd0, 5'd26), 64'h89AB_CDEF_8822_3344, 1, 1, 0, 64'h0000_0000_4433_2288, "R8 revw pos");
        // R9 zero-byte test
        issue(enc_un(7'b1000000, 5'd0, 5'd27), 64'h00FF_0012_0000_3400, 1, 1, 0, 64'hFF00_FF00_FFFF_00FF, "R9 ztest");
        issue(enc_un(7'b1000000, 5'd0, 5'd28), 64'h0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9 ztest zero");
        idle();
        // R10 disabled
        issue(enc_un(7'b1000001, 5'd0, 5'd29), 64'h1, 0, 0, 1, 64'h0, "R10 disabled rev");
        issue(enc_ext(0, 7, 0, 5'd30), 64'h1, 0, 0, 1, 64'h0, "R10 disabled ext");
        // R11 unmatched
        issue(enc_un(7'b1000000, 5'd1, 5'd2), 64'h1, 1, 0, 1, 64'h0, "R11 mid nonzero");
        issue(enc_un(7'b1111111, 5'd0, 5'd2), 64'h1, 1, 0, 1, 64'h0, "R11 bad top");
        issue({7'b1000001, 5'd0, 5'd3, 3'b000, 5'd2, OPC}, 64'h1, 1, 0, 1, 64'h0, "R11 funct3 000");
        issue({7'b1000001, 5'd0, 5'd3, 3'b111, 5'd2, OPC}, 64'h1, 1, 0, 1, 64'h0, "R11 funct3 111");
        // R1 foreign opcode, with and without enable
        issue({7'b1000001, 5'd0, 5'd3, 3'b001, 5'd2, 7'b0110011}, 64'h1, 1, 0, 0, 64'h0, "R1 foreign");
        issue({7'b1000001, 5'd0, 5'd3, 3'b001, 5'd2, 7'b0001111}, 64'h1, 0, 0, 0, 64'h0, "R1 foreign off");
        // R1 rd field follows bits 11:7
        issue(enc_un(7'b1000001, 5'd0, 5'd31), 64'h1, 1, 1, 0, 64'h0100_0000_0000_0000, "R1 rd31");
        idle();
        repeat (3) idle();

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12: got %0d pending exp 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule